// File: doc/BRIEF.md
# Store-Conditional Reservation Check Unit

This unit carries out the conditional-store half of a load-reserved / store-conditional pair for a single hart. It keeps one reservation, consisting of a physical address and an access width, which a load-reserved event writes. A later conditional-store request brings a virtual address, a width (4 or 8 bytes on a 64-bit datapath), store data and the two ordering bits. The unit then works through its checks in a fixed order. It first tests natural alignment locally. It then asks an external translator for the physical address and an external physical access checker for permission. Only after those does it compare the reservation. If every check passes, it issues a write to memory.

Each accepted request ends in exactly one registered, one-cycle pulse. One kind of pulse is a result of 0 (stored) or 1 (not stored), zero-extended to 64 bits. The other kind is an exception cause. The permission check always runs before the reservation test, so an access fault is never masked by a failure that happened to occur first. When the instruction retires, the reservation is dropped whatever the result. When it ends in an exception, the reservation is kept.

Top module: `sc_resv_unit`

## Requirements
- R1: A request whose virtual address is not a multiple of its width (width select 1 = 8 bytes, 0 = 4 bytes) ends in an exception with cause 6. No translation request is issued.
- R2: A translator response with its fault flag set ends in an exception carrying the translator's 5-bit cause (e.g. 15). No access-check request is issued.
- R3: After a good translation, the access checker receives the physical address and width. A fault from it ends in an exception with cause 7 and no memory write, even when the reservation would not match.
- R4: The reservation matches only if it is valid and its stored physical address and width both equal the translated address and the request width. A load-reserved event sets the reservation and replaces any older one. The virtual address plays no part in the match.
- R5: If the spurious-failure input is high when the reservation test is made, the outcome is the same as a mismatch.
- R6: On a mismatch, the result is 1 and no memory write is issued. When the write is reported performed, the result is 0. When it is reported not performed, the result is 1. A write fault ends in an exception with cause 7.
- R7: Every result (retirement) clears the reservation. An exception leaves it unchanged. A load-reserved event in the same cycle as a clear wins.
- R8: For a 4-byte store, the write data carries only the low 32 bits of the store data, with the upper 32 bits zero. For an 8-byte store, it carries all 64 bits. The write's acquire flag equals aq AND rl, and its release flag equals rl.
- R9: Each accepted request produces exactly one one-cycle pulse, either on res_valid or on exc_valid, never both. The result value has only bit 0 possibly set. Requests are taken only while req_ready is high.
- R10: After synchronous reset, there is no reservation, req_ready is high, and no request or response pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_valid | input | 1 | Load-reserved event: set reservation |
| lr_paddr | input | PA_W | Physical address of the load-reserved |
| lr_wide | input | 1 | Load-reserved width, 1 = 8 bytes |
| req_valid | input | 1 | Conditional-store request |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_vaddr | input | VA_W | Virtual address |
| req_wide | input | 1 | Width, 1 = 8 bytes, 0 = 4 bytes |
| req_data | input | XLEN | Store data register value |
| req_aq | input | 1 | Acquire ordering bit |
| req_rl | input | 1 | Release ordering bit |
| spur_fail | input | 1 | Force a spurious failure at the reservation test |
| xl_req_valid | output | 1 | Translation request |
| xl_req_vaddr | output | VA_W | Address to translate |
| xl_rsp_valid | input | 1 | Translation response |
| xl_rsp_fault | input | 1 | Translation failed |
| xl_rsp_cause | input | 5 | Cause code on failure |
| xl_rsp_paddr | input | PA_W | Translated physical address |
| pc_req_valid | output | 1 | Physical access check request |
| pc_req_paddr | output | PA_W | Address to check |
| pc_req_wide | output | 1 | Width to check |
| pc_rsp_valid | input | 1 | Access check response |
| pc_rsp_fault | input | 1 | Access not permitted |
| mw_req_valid | output | 1 | Memory write request |
| mw_req_paddr | output | PA_W | Write address |
| mw_req_wide | output | 1 | Write width |
| mw_req_data | output | XLEN | Write data, masked to width |
| mw_req_acq | output | 1 | Acquire flag |
| mw_req_rel | output | 1 | Release flag |
| mw_rsp_valid | input | 1 | Write response |
| mw_rsp_done | input | 1 | Write was performed |
| mw_rsp_fault | input | 1 | Write raised a fault |
| res_valid | output | 1 | Result pulse |
| res_value | output | XLEN | Destination value, 0 or 1 |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 5 | Exception cause |

## Verification
The bench targets priority between faults and the reservation test. It pairs a mismatched reservation with an access fault: a unit that tests the reservation first would return 1 where cause 7 is expected. After each misaligned, translation-fault and write-fault exception, the bench issues a second store to the same address. That store must succeed, so a unit that cleared the reservation on exceptions would report 1. It also covers a load-reserved made on the untranslated address, a reservation whose width differs from the store's, and a replaced reservation. A unit that compared virtual addresses or ignored width would report success in those cases. Finally, the bench checks the write data for 4-byte stores and the acquire and release flags, which catches a unit that passes unmasked data or the raw aq bit.

// File: rtl/sc_resv_pkg.sv
package sc_resv_pkg;
  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_MISALIGN = 5'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_ST_ACCESS   = 5'd7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XLATE = 2'd1,
    ST_PCHK  = 2'd2,
    ST_WRITE = 2'd3
  } sc_state_e;
endpackage

// File: rtl/sc_align_chk.sv
module sc_align_chk #(
  parameter int VA_W = 48,
  parameter int XLEN = 64
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            wide,
  output logic            misaligned
);
  localparam int WIDE_LSB   = $clog2(XLEN / 8);
  localparam int NARROW_LSB = WIDE_LSB - 1;

  always_comb begin
    if (wide) misaligned = (vaddr[WIDE_LSB-1:0] != '0);
    else      misaligned = (vaddr[NARROW_LSB-1:0] != '0);
  end
endmodule

// File: rtl/sc_resv_reg.sv
module sc_resv_reg #(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [PA_W-1:0] set_paddr,
  input  logic            set_wide,
  input  logic            clr_en,
  input  logic [PA_W-1:0] chk_paddr,
  input  logic            chk_wide,
  output logic            hit
);
  logic            rv_q;
  logic [PA_W-1:0] ra_q;
  logic            rw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q <= 1'b0;
      ra_q <= '0;
      rw_q <= 1'b0;
    end else if (set_en) begin
      rv_q <= 1'b1;
      ra_q <= set_paddr;
      rw_q <= set_wide;
    end else if (clr_en) begin
      rv_q <= 1'b0;
    end
  end

  assign hit = rv_q && (ra_q == chk_paddr) && (rw_q == chk_wide);
endmodule

// File: rtl/sc_step_ctrl.sv
module sc_step_ctrl
  import sc_resv_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 40,
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_wide,
  input  logic [XLEN-1:0]    req_data,
  input  logic               req_aq,
  input  logic               req_rl,
  input  logic               misaligned,
  input  logic               spur_fail,
  output logic               xl_req_valid,
  output logic [VA_W-1:0]    xl_req_vaddr,
  input  logic               xl_rsp_valid,
  input  logic               xl_rsp_fault,
  input  logic [CAUSE_W-1:0] xl_rsp_cause,
  input  logic [PA_W-1:0]    xl_rsp_paddr,
  output logic               pc_req_valid,
  output logic [PA_W-1:0]    pc_req_paddr,
  output logic               pc_req_wide,
  input  logic               pc_rsp_valid,
  input  logic               pc_rsp_fault,
  input  logic               resv_hit,
  output logic [PA_W-1:0]    resv_paddr,
  output logic               resv_wide,
  output logic               resv_clr,
  output logic               mw_req_valid,
  output logic [PA_W-1:0]    mw_req_paddr,
  output logic               mw_req_wide,
  output logic [XLEN-1:0]    mw_req_data,
  output logic               mw_req_acq,
  output logic               mw_req_rel,
  input  logic               mw_rsp_valid,
  input  logic               mw_rsp_done,
  input  logic               mw_rsp_fault,
  output logic               res_valid,
  output logic [XLEN-1:0]    res_value,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause
);
  localparam int HALF = XLEN / 2;

  sc_state_e            state_q;
  logic [VA_W-1:0]      va_q;
  logic [PA_W-1:0]      pa_q;
  logic                 wide_q;
  logic [XLEN-1:0]      data_q;
  logic                 acq_q;
  logic                 rel_q;
  logic                 res_bit_q;
  logic                 pc_pass;
  logic                 sc_lost;
  logic                 wr_retire;

  assign pc_pass   = (state_q == ST_PCHK) && pc_rsp_valid && !pc_rsp_fault;
  assign sc_lost   = spur_fail || !resv_hit;
  assign wr_retire = (state_q == ST_WRITE) && mw_rsp_valid && !mw_rsp_fault;
  assign resv_clr  = (pc_pass && sc_lost) || wr_retire;

  assign req_ready    = (state_q == ST_IDLE);
  assign xl_req_valid = (state_q == ST_XLATE);
  assign xl_req_vaddr = va_q;
  assign pc_req_valid = (state_q == ST_PCHK);
  assign pc_req_paddr = pa_q;
  assign pc_req_wide  = wide_q;
  assign resv_paddr   = pa_q;
  assign resv_wide    = wide_q;
  assign mw_req_valid = (state_q == ST_WRITE);
  assign mw_req_paddr = pa_q;
  assign mw_req_wide  = wide_q;
  assign mw_req_data  = data_q;
  assign mw_req_acq   = acq_q;
  assign mw_req_rel   = rel_q;
  assign res_value    = {{(XLEN-1){1'b0}}, res_bit_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      va_q      <= '0;
      pa_q      <= '0;
      wide_q    <= 1'b0;
      data_q    <= '0;
      acq_q     <= 1'b0;
      rel_q     <= 1'b0;
      res_bit_q <= 1'b0;
      res_valid <= 1'b0;
      exc_valid <= 1'b0;
      exc_cause <= '0;
    end else begin
      res_valid <= 1'b0;
      exc_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            wide_q <= req_wide;
            data_q <= req_wide ? req_data : {{HALF{1'b0}}, req_data[HALF-1:0]};
            acq_q  <= req_aq & req_rl;
            rel_q  <= req_rl;
            if (misaligned) begin
              exc_valid <= 1'b1;
              exc_cause <= CAUSE_ST_MISALIGN;
            end else begin
              state_q <= ST_XLATE;
            end
          end
        end
        ST_XLATE: begin
          if (xl_rsp_valid) begin
            if (xl_rsp_fault) begin
              exc_valid <= 1'b1;
              exc_cause <= xl_rsp_cause;
              state_q   <= ST_IDLE;
            end else begin
              pa_q    <= xl_rsp_paddr;
              state_q <= ST_PCHK;
            end
          end
        end
        ST_PCHK: begin
          if (pc_rsp_valid) begin
            if (pc_rsp_fault) begin
              exc_valid <= 1'b1;
              exc_cause <= CAUSE_ST_ACCESS;
              state_q   <= ST_IDLE;
            end else if (sc_lost) begin
              res_valid <= 1'b1;
              res_bit_q <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (mw_rsp_valid) begin
            state_q <= ST_IDLE;
            if (mw_rsp_fault) begin
              exc_valid <= 1'b1;
              exc_cause <= CAUSE_ST_ACCESS;
            end else begin
              res_valid <= 1'b1;
              res_bit_q <= !mw_rsp_done;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_resv_unit.sv
module sc_resv_unit
  import sc_resv_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 40,
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lr_valid,
  input  logic [PA_W-1:0]    lr_paddr,
  input  logic               lr_wide,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_wide,
  input  logic [XLEN-1:0]    req_data,
  input  logic               req_aq,
  input  logic               req_rl,
  input  logic               spur_fail,
  output logic               xl_req_valid,
  output logic [VA_W-1:0]    xl_req_vaddr,
  input  logic               xl_rsp_valid,
  input  logic               xl_rsp_fault,
  input  logic [CAUSE_W-1:0] xl_rsp_cause,
  input  logic [PA_W-1:0]    xl_rsp_paddr,
  output logic               pc_req_valid,
  output logic [PA_W-1:0]    pc_req_paddr,
  output logic               pc_req_wide,
  input  logic               pc_rsp_valid,
  input  logic               pc_rsp_fault,
  output logic               mw_req_valid,
  output logic [PA_W-1:0]    mw_req_paddr,
  output logic               mw_req_wide,
  output logic [XLEN-1:0]    mw_req_data,
  output logic               mw_req_acq,
  output logic               mw_req_rel,
  input  logic               mw_rsp_valid,
  input  logic               mw_rsp_done,
  input  logic               mw_rsp_fault,
  output logic               res_valid,
  output logic [XLEN-1:0]    res_value,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause
);
  logic            misaligned;
  logic            resv_hit;
  logic            resv_clr;
  logic [PA_W-1:0] resv_paddr;
  logic            resv_wide;

  sc_align_chk #(.VA_W(VA_W), .XLEN(XLEN)) u_align (
    .vaddr      (req_vaddr),
    .wide       (req_wide),
    .misaligned (misaligned)
  );

  sc_resv_reg #(.PA_W(PA_W)) u_resv (
    .clk       (clk),
    .rst       (rst),
    .set_en    (lr_valid),
    .set_paddr (lr_paddr),
    .set_wide  (lr_wide),
    .clr_en    (resv_clr),
    .chk_paddr (resv_paddr),
    .chk_wide  (resv_wide),
    .hit       (resv_hit)
  );

  sc_step_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .XLEN(XLEN)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .req_wide     (req_wide),
    .req_data     (req_data),
    .req_aq       (req_aq),
    .req_rl       (req_rl),
    .misaligned   (misaligned),
    .spur_fail    (spur_fail),
    .xl_req_valid (xl_req_valid),
    .xl_req_vaddr (xl_req_vaddr),
    .xl_rsp_valid (xl_rsp_valid),
    .xl_rsp_fault (xl_rsp_fault),
    .xl_rsp_cause (xl_rsp_cause),
    .xl_rsp_paddr (xl_rsp_paddr),
    .pc_req_valid (pc_req_valid),
    .pc_req_paddr (pc_req_paddr),
    .pc_req_wide  (pc_req_wide),
    .pc_rsp_valid (pc_rsp_valid),
    .pc_rsp_fault (pc_rsp_fault),
    .resv_hit     (resv_hit),
    .resv_paddr   (resv_paddr),
    .resv_wide    (resv_wide),
    .resv_clr     (resv_clr),
    .mw_req_valid (mw_req_valid),
    .mw_req_paddr (mw_req_paddr),
    .mw_req_wide  (mw_req_wide),
    .mw_req_data  (mw_req_data),
    .mw_req_acq   (mw_req_acq),
    .mw_req_rel   (mw_req_rel),
    .mw_rsp_valid (mw_rsp_valid),
    .mw_rsp_done  (mw_rsp_done),
    .mw_rsp_fault (mw_rsp_fault),
    .res_valid    (res_valid),
    .res_value    (res_value),
    .exc_valid    (exc_valid),
    .exc_cause    (exc_cause)
  );
endmodule

// File: rtl/sc_resv_unit_chk.sv
module sc_resv_unit_chk #(
  parameter int VA_W = 48,
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_wide,
  input logic            req_aq,
  input logic            req_rl,
  input logic            xl_req_valid,
  input logic            xl_rsp_valid,
  input logic            xl_rsp_fault,
  input logic [4:0]      xl_rsp_cause,
  input logic            pc_req_valid,
  input logic            pc_rsp_valid,
  input logic            pc_rsp_fault,
  input logic            mw_req_valid,
  input logic            mw_req_wide,
  input logic [XLEN-1:0] mw_req_data,
  input logic            mw_req_acq,
  input logic            mw_req_rel,
  input logic            mw_rsp_valid,
  input logic            mw_rsp_done,
  input logic            mw_rsp_fault,
  input logic            res_valid,
  input logic [XLEN-1:0] res_value,
  input logic            exc_valid,
  input logic [4:0]      exc_cause
);
  localparam int WB = $clog2(XLEN / 8);
  localparam int HALF = XLEN / 2;

  logic take;
  logic bad_align;
  logic acq_exp;
  logic rel_exp;

  assign take      = req_valid && req_ready;
  assign bad_align = req_wide ? (req_vaddr[WB-1:0] != '0) : (req_vaddr[WB-2:0] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acq_exp <= 1'b0;
      rel_exp <= 1'b0;
    end else if (take) begin
      acq_exp <= req_aq && req_rl;
      rel_exp <= req_rl;
    end
  end

  // R1
  a_r1_misalign_exc: assert property (@(posedge clk) disable iff (rst)
    (take && bad_align) |=> (exc_valid && exc_cause == 5'd6 && !xl_req_valid));

  // R2
  a_r2_xlate_fault: assert property (@(posedge clk) disable iff (rst)
    (xl_req_valid && xl_rsp_valid && xl_rsp_fault) |=>
      (exc_valid && exc_cause == $past(xl_rsp_cause) && !pc_req_valid));

  // R3
  a_r3_access_fault: assert property (@(posedge clk) disable iff (rst)
    (pc_req_valid && pc_rsp_valid && pc_rsp_fault) |=>
      (exc_valid && exc_cause == 5'd7 && !mw_req_valid && !res_valid));

  // R6
  a_r6_write_result: assert property (@(posedge clk) disable iff (rst)
    (mw_req_valid && mw_rsp_valid && !mw_rsp_fault) |=>
      (res_valid && res_value[0] == !$past(mw_rsp_done)));

  a_r6_write_fault: assert property (@(posedge clk) disable iff (rst)
    (mw_req_valid && mw_rsp_valid && mw_rsp_fault) |=> (exc_valid && exc_cause == 5'd7));

  // R8
  a_r8_narrow_mask: assert property (@(posedge clk) disable iff (rst)
    (mw_req_valid && !mw_req_wide) |-> (mw_req_data[XLEN-1:HALF] == '0));

  a_r8_order_flags: assert property (@(posedge clk) disable iff (rst)
    mw_req_valid |-> (mw_req_acq == acq_exp && mw_req_rel == rel_exp));

  // R9
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && exc_valid));

  a_r9_zero_ext: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_value[XLEN-1:1] == '0));

  a_r9_pulse_len: assert property (@(posedge clk) disable iff (rst)
    (res_valid || exc_valid) |=> !(res_valid || exc_valid));
endmodule

bind sc_resv_unit sc_resv_unit_chk #(.VA_W(VA_W), .XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_vaddr    (req_vaddr),
  .req_wide     (req_wide),
  .req_aq       (req_aq),
  .req_rl       (req_rl),
  .xl_req_valid (xl_req_valid),
  .xl_rsp_valid (xl_rsp_valid),
  .xl_rsp_fault (xl_rsp_fault),
  .xl_rsp_cause (xl_rsp_cause),
  .pc_req_valid (pc_req_valid),
  .pc_rsp_valid (pc_rsp_valid),
  .pc_rsp_fault (pc_rsp_fault),
  .mw_req_valid (mw_req_valid),
  .mw_req_wide  (mw_req_wide),
  .mw_req_data  (mw_req_data),
  .mw_req_acq   (mw_req_acq),
  .mw_req_rel   (mw_req_rel),
  .mw_rsp_valid (mw_rsp_valid),
  .mw_rsp_done  (mw_rsp_done),
  .mw_rsp_fault (mw_rsp_fault),
  .res_valid    (res_valid),
  .res_value    (res_value),
  .exc_valid    (exc_valid),
  .exc_cause    (exc_cause)
);

// File: tb/sc_resv_unit_tb.sv
`timescale 1ns/1ps
module sc_resv_unit_tb;
  localparam int VA_W = 48;
  localparam int PA_W = 40;
  localparam int XLEN = 64;
  localparam logic [PA_W-1:0] PA_OFS = 40'h10_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic            lr_valid = 0;
  logic [PA_W-1:0] lr_paddr = '0;
  logic            lr_wide = 0;
  logic            req_valid = 0;
  logic            req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic            req_wide = 0;
  logic [XLEN-1:0] req_data = '0;
  logic            req_aq = 0;
  logic            req_rl = 0;
  logic            spur_fail = 0;
  logic            xl_req_valid;
  logic [VA_W-1:0] xl_req_vaddr;
  logic            xl_rsp_valid;
  logic            xl_rsp_fault;
  logic [4:0]      xl_rsp_cause;
  logic [PA_W-1:0] xl_rsp_paddr;
  logic            pc_req_valid;
  logic [PA_W-1:0] pc_req_paddr;
  logic            pc_req_wide;
  logic            pc_rsp_valid;
  logic            pc_rsp_fault;
  logic            mw_req_valid;
  logic [PA_W-1:0] mw_req_paddr;
  logic            mw_req_wide;
  logic [XLEN-1:0] mw_req_data;
  logic            mw_req_acq;
  logic            mw_req_rel;
  logic            mw_rsp_valid;
  logic            mw_rsp_done;
  logic            mw_rsp_fault;
  logic            res_valid;
  logic [XLEN-1:0] res_value;
  logic            exc_valid;
  logic [4:0]      exc_cause;

  // stub configuration
  logic       cfg_xl_fault = 0;
  logic [4:0] cfg_xl_cause = 5'd15;
  logic       cfg_pc_fault = 0;
  logic       cfg_mw_fault = 0;
  logic       cfg_mw_done  = 1;

  int n_xl = 0, n_pc = 0, n_mw = 0, n_pulse = 0;
  logic [PA_W-1:0] last_pc_pa;
  logic            last_pc_wide;
  logic [PA_W-1:0] last_mw_pa;
  logic [XLEN-1:0] last_mw_data;
  logic            last_acq, last_rel;

  int total = 0, bad = 0;

  // reference reservation model
  logic            m_rv = 0;
  logic [PA_W-1:0] m_ra = '0;
  logic            m_rw = 0;

  sc_resv_unit #(.VA_W(VA_W), .PA_W(PA_W), .XLEN(XLEN)) u_dut (.*);

  // translator, access checker and memory stubs
  always @(posedge clk) begin
    if (rst) begin
      xl_rsp_valid <= 0; xl_rsp_fault <= 0; xl_rsp_cause <= 0; xl_rsp_paddr <= '0;
      pc_rsp_valid <= 0; pc_rsp_fault <= 0;
      mw_rsp_valid <= 0; mw_rsp_done <= 0; mw_rsp_fault <= 0;
    end else begin
      xl_rsp_valid <= xl_req_valid && !xl_rsp_valid;
      xl_rsp_fault <= cfg_xl_fault;
      xl_rsp_cause <= cfg_xl_cause;
      xl_rsp_paddr <= xl_req_vaddr[PA_W-1:0] + PA_OFS;
      pc_rsp_valid <= pc_req_valid && !pc_rsp_valid;
      pc_rsp_fault <= cfg_pc_fault;
      mw_rsp_valid <= mw_req_valid && !mw_rsp_valid;
      mw_rsp_done  <= cfg_mw_done;
      mw_rsp_fault <= cfg_mw_fault;
      if (xl_req_valid && xl_rsp_valid) n_xl <= n_xl + 1;
      if (pc_req_valid && pc_rsp_valid) begin
        n_pc <= n_pc + 1; last_pc_pa <= pc_req_paddr; last_pc_wide <= pc_req_wide;
      end
      if (mw_req_valid && mw_rsp_valid) begin
        n_mw <= n_mw + 1; last_mw_pa <= mw_req_paddr; last_mw_data <= mw_req_data;
        last_acq <= mw_req_acq; last_rel <= mw_req_rel;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // every clock: both pulses never together
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid || exc_valid) n_pulse++;
      if (res_valid && exc_valid) chk(0, "R9 both pulses", 64'd1, 64'd0);
    end
  end

  task automatic do_lr(input logic [PA_W-1:0] pa, input logic wide);
    @(negedge clk);
    lr_valid = 1; lr_paddr = pa; lr_wide = wide;
    @(negedge clk);
    lr_valid = 0;
    m_rv = 1; m_ra = pa; m_rw = wide;
  endtask

  task automatic do_sc(input logic [VA_W-1:0] va, input logic wide, input logic [63:0] data,
                       input logic aq, input logic rl, input string tag);
    logic mis, e_exc, e_write, e_pc, e_xl, seen;
    logic [4:0] e_cause;
    logic e_val;
    logic [PA_W-1:0] pa;
    logic [63:0] e_data;
    int xl0, pc0, mw0, pl0;
    mis = wide ? (va[2:0] != 0) : (va[1:0] != 0);
    pa = va[PA_W-1:0] + PA_OFS;
    e_exc = 0; e_write = 0; e_pc = 0; e_xl = 0; e_cause = 0; e_val = 0;
    e_data = wide ? data : {32'b0, data[31:0]};
    if (mis) begin e_exc = 1; e_cause = 5'd6; end
    else if (cfg_xl_fault) begin e_xl = 1; e_exc = 1; e_cause = cfg_xl_cause; end
    else if (cfg_pc_fault) begin e_xl = 1; e_pc = 1; e_exc = 1; e_cause = 5'd7; end
    else if (spur_fail || !(m_rv && m_ra == pa && m_rw == wide)) begin
      e_xl = 1; e_pc = 1; e_val = 1; m_rv = 0;
    end else begin
      e_xl = 1; e_pc = 1; e_write = 1;
      if (cfg_mw_fault) begin e_exc = 1; e_cause = 5'd7; end
      else begin e_val = !cfg_mw_done; m_rv = 0; end
    end
    xl0 = n_xl; pc0 = n_pc; mw0 = n_mw; pl0 = n_pulse;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_wide = wide; req_data = data; req_aq = aq; req_rl = rl;
    @(negedge clk);
    req_valid = 0;
    seen = 0;
    for (int i = 0; i < 60 && !seen; i++) begin
      if (res_valid || exc_valid) seen = 1;
      else @(negedge clk);
    end
    chk(seen, {tag, " R9 outcome seen"}, 64'(seen), 64'd1);
    if (seen) begin
      chk(exc_valid == e_exc, {tag, " kind"}, 64'(exc_valid), 64'(e_exc));
      if (e_exc) chk(exc_cause == e_cause, {tag, " cause"}, 64'(exc_cause), 64'(e_cause));
      else chk(res_value == 64'(e_val), {tag, " result"}, res_value, 64'(e_val));
    end
    chk((n_xl - xl0) == int'(e_xl), {tag, " translation count"}, 64'(n_xl - xl0), 64'(e_xl));
    chk((n_pc - pc0) == int'(e_pc), {tag, " access-check count"}, 64'(n_pc - pc0), 64'(e_pc));
    chk((n_mw - mw0) == int'(e_write), {tag, " write count"}, 64'(n_mw - mw0), 64'(e_write));
    if (e_pc) chk(last_pc_pa == pa && last_pc_wide == wide, {tag, " R3 check addr"},
                  64'(last_pc_pa), 64'(pa));
    if (e_write) begin
      chk(last_mw_pa == pa, {tag, " R4 write addr"}, 64'(last_mw_pa), 64'(pa));
      chk(last_mw_data == e_data, {tag, " R8 write data"}, last_mw_data, e_data);
      chk(last_acq == (aq && rl) && last_rel == rl, {tag, " R8 flags"},
          {62'b0, last_acq, last_rel}, {62'b0, aq && rl, rl});
    end
    @(negedge clk);
    chk(!res_valid && !exc_valid, {tag, " R9 single pulse"}, 64'(res_valid | exc_valid), 64'd0);
    chk((n_pulse - pl0) == 1, {tag, " R9 pulse count"}, 64'(n_pulse - pl0), 64'd1);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1, "R10 ready", 64'(req_ready), 64'd1);
    chk(!res_valid && !exc_valid, "R10 pulses", 64'(res_valid | exc_valid), 64'd0);
    chk(!xl_req_valid && !pc_req_valid && !mw_req_valid, "R10 requests",
        64'(xl_req_valid | pc_req_valid | mw_req_valid), 64'd0);

    do_sc(48'h100, 1, 64'h1111, 0, 0, "R10 R4 no reservation");
    do_lr(40'h100 + PA_OFS, 1);
    do_sc(48'h100, 1, 64'hA5A5_0000_1234_5678, 1, 1, "R6 wide success");
    do_sc(48'h100, 1, 64'h2222, 0, 1, "R7 cleared after retire");

    do_lr(40'h204 + PA_OFS, 0);
    do_sc(48'h204, 0, 64'hDEAD_BEEF_1234_5678, 1, 0, "R8 narrow mask");

    do_lr(40'h300 + PA_OFS, 1);
    do_sc(48'h304, 1, 64'h3, 0, 0, "R1 wide misaligned");
    do_sc(48'h302, 0, 64'h3, 0, 0, "R1 narrow misaligned");
    do_sc(48'h300, 1, 64'h33, 0, 1, "R7 kept after misalign");

    do_lr(40'h400 + PA_OFS, 1);
    cfg_xl_fault = 1; cfg_xl_cause = 5'd15;
    do_sc(48'h400, 1, 64'h4, 0, 0, "R2 page fault");
    cfg_xl_cause = 5'd13;
    do_sc(48'h400, 1, 64'h4, 0, 0, "R2 other cause");
    cfg_xl_fault = 0;
    do_sc(48'h400, 1, 64'h44, 0, 0, "R7 kept after xlate fault");

    cfg_pc_fault = 1;
    do_sc(48'h480, 1, 64'h5, 0, 0, "R3 fault beats mismatch");
    spur_fail = 1;
    do_sc(48'h480, 1, 64'h5, 0, 0, "R3 fault beats spurious");
    spur_fail = 0;
    do_lr(40'h480 + PA_OFS, 1);
    do_sc(48'h480, 1, 64'h5, 0, 0, "R3 fault with reservation");
    cfg_pc_fault = 0;
    do_sc(48'h480, 1, 64'h55, 0, 0, "R7 kept after access fault");

    do_lr(40'h500 + PA_OFS, 1);
    spur_fail = 1;
    do_sc(48'h500, 1, 64'h6, 0, 0, "R5 spurious");
    spur_fail = 0;
    do_sc(48'h500, 1, 64'h6, 0, 0, "R5 R7 cleared by spurious");

    do_lr(40'h600 + PA_OFS, 1);
    cfg_mw_done = 0;
    do_sc(48'h600, 1, 64'h7, 0, 1, "R6 write not performed");
    cfg_mw_done = 1;
    do_sc(48'h600, 1, 64'h7, 0, 0, "R7 cleared after not performed");

    do_lr(40'h700 + PA_OFS, 0);
    cfg_mw_fault = 1;
    do_sc(48'h700, 0, 64'h8, 1, 1, "R6 write fault");
    cfg_mw_fault = 0;
    do_sc(48'h700, 0, 64'h88, 1, 1, "R7 kept after write fault");

    do_lr(40'h800 + PA_OFS, 0);
    do_sc(48'h800, 1, 64'h9, 0, 0, "R4 width mismatch");
    do_lr(40'h900 + PA_OFS, 1);
    do_lr(40'hA00 + PA_OFS, 1);
    do_sc(48'h900, 1, 64'h9, 0, 0, "R4 replaced reservation");
    do_lr(40'h900 + PA_OFS, 1);
    do_lr(40'hA00 + PA_OFS, 1);
    do_sc(48'hA00, 1, 64'hA, 0, 0, "R4 newest reservation");
    do_lr(40'hB00, 1);
    do_sc(48'hB00, 1, 64'hB, 0, 0, "R4 virtual address not used");
    do_lr(40'hB00 + PA_OFS, 1);
    do_sc(48'hB00, 1, 64'hB, 0, 0, "R4 physical address match");

    for (int k = 0; k < 8; k++) begin
      do_lr(40'hC00 + 40'(k * 8) + PA_OFS, k[0]);
      do_sc(48'hC00 + 48'(k * 8), k[0], 64'hF00D_0000_0000_0000 | 64'(k), k[1], k[2], "R6 R8 sweep");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule